// File: doc/BRIEF.md
# Effective Address and Next-PC Select Unit

This unit computes memory addresses and the next program counter for a 16-bit, word-addressed processor with a 64K-word space. Each operation arrives as an operation-kind code along with the low nine bits of the instruction register. It also receives the current PC register value, which has already been advanced past the instruction, a base register value and a bus value. From these it produces the MAR value and its source select, the next PC and its source select, and an address result that is written back to a register.

One shared adder serves every address. It forms either the PC plus a sign-extended 9-bit offset, or the base register plus a sign-extended 6-bit offset, or the register value with no offset. Direct operations produce their results in the same cycle they are presented. An indirect access takes several cycles. The unit first presents the pointer location and reads that word through a request/ready handshake. It then presents the word it read as the final address. While this sequence runs, new operations are refused.

Top module: `eap_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `memReq`, `marLoad`, `pcLoad` and `leaWrite` are low.
- R2: Kind 0 (fetch), when valid and idle, asserts `pcLoad` with `pcSel`=0 and `pcNext` = `pcVal`+1, wrapping modulo 65536, in the same cycle.
- R3: Kinds 4 and 5 (PC-relative load/store) assert `marLoad` with `marSel`=0 and `marAddr` = `pcVal` + sign-extended `irField[8:0]`, modulo 65536, in the same cycle, without `memReq`.
- R4: Kinds 6 and 7 (base-offset load/store) assert `marLoad` with `marSel`=0 and `marAddr` = `baseVal` + sign-extended `irField[5:0]`, modulo 65536, in the same cycle.
- R5: Kind 10 (address calculation) asserts `leaWrite` with `leaValue` = `pcVal` + sign-extended `irField[8:0]`, and asserts neither `marLoad` nor `memReq` nor `pcLoad`.
- R6: Kind 1 (taken branch) gives `pcSel`=1 and `pcNext` = `pcVal` + sign-extended `irField[8:0]`. Kind 2 (register jump) gives `pcSel`=1 and `pcNext` = `baseVal`. Both assert `pcLoad`.
- R7: Kind 3 (trap) asserts `marLoad` with `marSel`=1 and `marAddr` = zero-extended `irField[7:0]`. In the same cycle it asserts `pcLoad` with `pcSel`=2 and `pcNext` = `busVal`.
- R8: Kinds 8 and 9 (indirect load/store) set `busy` from the next cycle. In that cycle `memReq`, `marLoad`, `marSel`=2 and `marAddr` = `pcVal` + sign-extended `irField[8:0]` (the value captured when the operation was accepted) are all asserted. `memReq` and `marAddr` then hold, with `marLoad` low, until `memReady` is sampled high.
- R9: In the cycle after `memReady` is sampled high during a pointer read, `marLoad` is asserted with `marSel`=3 and `marAddr` equal to the `memRdata` sampled with `memReady`, and `memReq` is low. In the cycle after that, `busy` is low.
- R10: While `busy` is high, `opValid` has no effect: `pcLoad` and `leaWrite` stay low, and the pointer address and final address are unchanged by `irField`, `pcVal` or `opKind`.
- R11: Kinds 11 to 15 assert no strobe and do not start a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Operation presented this cycle |
| opKind | input | 4 | Operation kind code (see requirements) |
| irField | input | 9 | Instruction register bits 8..0 |
| pcVal | input | 16 | PC register value, already incremented past the instruction |
| baseVal | input | 16 | Base or jump register value |
| busVal | input | 16 | Bus value used as the trap PC |
| memRdata | input | 16 | Memory read data for the pointer read |
| memReady | input | 1 | Memory read complete |
| busy | output | 1 | Indirect sequence in progress |
| memReq | output | 1 | Pointer read request |
| marLoad | output | 1 | MAR load strobe |
| marSel | output | 2 | MAR source: 0 adder, 1 trap vector, 2 pointer location, 3 fetched pointer |
| marAddr | output | 16 | Value selected for the MAR |
| pcLoad | output | 1 | PC load strobe |
| pcSel | output | 2 | PC source: 0 increment, 1 adder, 2 bus |
| pcNext | output | 16 | Value selected for the PC |
| leaWrite | output | 1 | Register write strobe for the computed address |
| leaValue | output | 16 | Computed address for register write |

## Verification
Offsets at the extremes of each field are used: +255 and -256 on the 9-bit field, +31 and -32 on the 6-bit field. They are applied to PC and base values near 0x0000 and 0xFFFF. These cases separate correct sign extension and modulo-65536 wrap from zero extension or a wrong field width. A trap vector with bit 8 set shows that the vector path drops that bit. Indirect accesses are run with zero wait cycles and with several. During the wait the PC, the IR field and a competing operation keep changing. This separates a latched pointer location, a held request and a correctly timed final address from logic that follows live inputs. Random mixes of all sixteen kind codes, including the unused ones, confirm that each kind drives only its own strobes.

// File: rtl/eap_pkg.sv
package eap_pkg;
  localparam int ADDR_W = 16;
  localparam int KIND_W = 4;

  localparam logic [KIND_W-1:0] K_FETCH     = 4'd0;
  localparam logic [KIND_W-1:0] K_BRANCH    = 4'd1;
  localparam logic [KIND_W-1:0] K_JUMP      = 4'd2;
  localparam logic [KIND_W-1:0] K_TRAP      = 4'd3;
  localparam logic [KIND_W-1:0] K_LOADPC    = 4'd4;
  localparam logic [KIND_W-1:0] K_STOREPC   = 4'd5;
  localparam logic [KIND_W-1:0] K_LOADBASE  = 4'd6;
  localparam logic [KIND_W-1:0] K_STOREBASE = 4'd7;
  localparam logic [KIND_W-1:0] K_LOADIND   = 4'd8;
  localparam logic [KIND_W-1:0] K_STOREIND  = 4'd9;
  localparam logic [KIND_W-1:0] K_ADDRCALC  = 4'd10;

  typedef enum logic [1:0] {AM_PCREL = 2'd0, AM_BASE = 2'd1, AM_REG = 2'd2} addrMode_e;
  typedef enum logic [1:0] {MS_ADDER = 2'd0, MS_TRAPVEC = 2'd1, MS_PTRLOC = 2'd2, MS_PTRWORD = 2'd3} marSel_e;
  typedef enum logic [1:0] {PS_INC = 2'd0, PS_ADDER = 2'd1, PS_BUS = 2'd2} pcSel_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_READ_PTR = 2'd1, ST_WAIT_PTR = 2'd2, ST_ACCESS = 2'd3} seqState_e;

  typedef struct packed {
    addrMode_e addrMode;
    marSel_e   marSel;
    pcSel_e    pcSel;
    logic      capPtrLoc;
    logic      capPtrWord;
  } dpCtrl_t;
endpackage

// File: rtl/eap_datapath.sv
module eap_datapath
  import eap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int FIELD_W   = 9,
  parameter int PCOFF_W   = 9,
  parameter int BASEOFF_W = 6,
  parameter int VEC_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [FIELD_W-1:0] irField,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] busVal,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] marAddr,
  output logic [ADDR_W-1:0] pcNext,
  output logic [ADDR_W-1:0] leaValue
);
  localparam int PC_EXT   = ADDR_W - PCOFF_W;
  localparam int BASE_EXT = ADDR_W - BASEOFF_W;
  localparam int VEC_EXT  = ADDR_W - VEC_W;

  logic [ADDR_W-1:0] pcOffset;
  logic [ADDR_W-1:0] baseOffset;
  logic [ADDR_W-1:0] trapVector;
  logic [ADDR_W-1:0] opA;
  logic [ADDR_W-1:0] opB;
  logic [ADDR_W-1:0] adderOut;
  logic [ADDR_W-1:0] ptrLoc;
  logic [ADDR_W-1:0] ptrWord;

  assign pcOffset   = {{PC_EXT{irField[PCOFF_W-1]}}, irField[PCOFF_W-1:0]};
  assign baseOffset = {{BASE_EXT{irField[BASEOFF_W-1]}}, irField[BASEOFF_W-1:0]};
  assign trapVector = {{VEC_EXT{1'b0}}, irField[VEC_W-1:0]};

  always_comb begin
    opA = (ctrl.addrMode == AM_PCREL) ? pcVal : baseVal;
    unique case (ctrl.addrMode)
      AM_PCREL: opB = pcOffset;
      AM_BASE:  opB = baseOffset;
      default:  opB = '0;
    endcase
  end

  assign adderOut = opA + opB;
  assign leaValue = adderOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrLoc  <= '0;
      ptrWord <= '0;
    end else begin
      if (ctrl.capPtrLoc)  ptrLoc  <= adderOut;
      if (ctrl.capPtrWord) ptrWord <= memRdata;
    end
  end

  always_comb begin
    unique case (ctrl.marSel)
      MS_ADDER:   marAddr = adderOut;
      MS_TRAPVEC: marAddr = trapVector;
      MS_PTRLOC:  marAddr = ptrLoc;
      default:    marAddr = ptrWord;
    endcase
  end

  always_comb begin
    unique case (ctrl.pcSel)
      PS_ADDER: pcNext = adderOut;
      PS_BUS:   pcNext = busVal;
      default:  pcNext = pcVal + ADDR_W'(1);
    endcase
  end
endmodule

// File: rtl/eap_control.sv
module eap_control
  import eap_pkg::*;
#(
  parameter int KIND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [KIND_W-1:0] opKind,
  input  logic              memReady,
  output dpCtrl_t           ctrl,
  output logic              marLoad,
  output logic              pcLoad,
  output logic              leaWrite,
  output logic              memReq,
  output logic              busy
);
  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    nextState        = state;
    ctrl.addrMode    = AM_PCREL;
    ctrl.marSel      = MS_ADDER;
    ctrl.pcSel       = PS_INC;
    ctrl.capPtrLoc   = 1'b0;
    ctrl.capPtrWord  = 1'b0;
    marLoad          = 1'b0;
    pcLoad           = 1'b0;
    leaWrite         = 1'b0;
    memReq           = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (opValid) begin
          case (opKind)
            K_FETCH: begin
              pcLoad = 1'b1;
            end
            K_BRANCH: begin
              pcLoad     = 1'b1;
              ctrl.pcSel = PS_ADDER;
            end
            K_JUMP: begin
              pcLoad        = 1'b1;
              ctrl.addrMode = AM_REG;
              ctrl.pcSel    = PS_ADDER;
            end
            K_TRAP: begin
              marLoad     = 1'b1;
              ctrl.marSel = MS_TRAPVEC;
              pcLoad      = 1'b1;
              ctrl.pcSel  = PS_BUS;
            end
            K_LOADPC, K_STOREPC: begin
              marLoad = 1'b1;
            end
            K_LOADBASE, K_STOREBASE: begin
              marLoad       = 1'b1;
              ctrl.addrMode = AM_BASE;
            end
            K_LOADIND, K_STOREIND: begin
              ctrl.capPtrLoc = 1'b1;
              nextState      = ST_READ_PTR;
            end
            K_ADDRCALC: begin
              leaWrite = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_READ_PTR, ST_WAIT_PTR: begin
        memReq      = 1'b1;
        marLoad     = (state == ST_READ_PTR);
        ctrl.marSel = MS_PTRLOC;
        if (memReady) begin
          ctrl.capPtrWord = 1'b1;
          nextState       = ST_ACCESS;
        end else begin
          nextState = ST_WAIT_PTR;
        end
      end
      default: begin
        marLoad     = 1'b1;
        ctrl.marSel = MS_PTRWORD;
        nextState   = ST_IDLE;
      end
    endcase
  end
endmodule

// File: rtl/eap_unit.sv
module eap_unit
  import eap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int KIND_W    = 4,
  parameter int FIELD_W   = 9,
  parameter int PCOFF_W   = 9,
  parameter int BASEOFF_W = 6,
  parameter int VEC_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [KIND_W-1:0] opKind,
  input  logic [FIELD_W-1:0] irField,
  input  logic [ADDR_W-1:0] pcVal,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] busVal,
  input  logic [ADDR_W-1:0] memRdata,
  input  logic              memReady,
  output logic              busy,
  output logic              memReq,
  output logic              marLoad,
  output logic [1:0]        marSel,
  output logic [ADDR_W-1:0] marAddr,
  output logic              pcLoad,
  output logic [1:0]        pcSel,
  output logic [ADDR_W-1:0] pcNext,
  output logic              leaWrite,
  output logic [ADDR_W-1:0] leaValue
);
  dpCtrl_t ctrl;

  eap_control #(.KIND_W(KIND_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .memReady(memReady), .ctrl(ctrl), .marLoad(marLoad), .pcLoad(pcLoad),
    .leaWrite(leaWrite), .memReq(memReq), .busy(busy)
  );

  eap_datapath #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .PCOFF_W(PCOFF_W),
    .BASEOFF_W(BASEOFF_W), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .irField(irField), .pcVal(pcVal),
    .baseVal(baseVal), .busVal(busVal), .memRdata(memRdata),
    .marAddr(marAddr), .pcNext(pcNext), .leaValue(leaValue)
  );

  assign marSel = ctrl.marSel;
  assign pcSel  = ctrl.pcSel;
endmodule

// File: rtl/eap_checker.sv
module eap_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic              memReady,
  input logic              marLoad,
  input logic [1:0]        marSel,
  input logic [ADDR_W-1:0] marAddr,
  input logic              pcLoad,
  input logic [1:0]        pcSel,
  input logic              leaWrite
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!busy && !memReq));

  assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && !marLoad && $stable(marAddr)));

  assert_req_only_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  assert_final_after_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> (marLoad && marSel == 2'd3 && !memReq));

  assert_final_then_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (marLoad && marSel == 2'd3) |=> !busy);

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!pcLoad && !leaWrite));

  assert_trap_pair_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && pcSel == 2'd2) |-> (marLoad && marSel == 2'd1));

  assert_calc_no_mem_R5: assert property (@(posedge clk) disable iff (!rstN)
    leaWrite |-> (!marLoad && !memReq && !pcLoad));
endmodule

bind eap_unit eap_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReq(memReq), .memReady(memReady),
  .marLoad(marLoad), .marSel(marSel), .marAddr(marAddr), .pcLoad(pcLoad),
  .pcSel(pcSel), .leaWrite(leaWrite)
);

// File: tb/sim_eap_unit.sv
`timescale 1ns/1ps
module sim_eap_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opKind = '0;
  logic [8:0]  irField = '0;
  logic [15:0] pcVal = '0, baseVal = '0, busVal = '0, memRdata = '0;
  logic        memReady = 1'b0;
  logic        busy, memReq, marLoad, pcLoad, leaWrite;
  logic [1:0]  marSel, pcSel;
  logic [15:0] marAddr, pcNext, leaValue;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  eap_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .irField(irField),
    .pcVal(pcVal), .baseVal(baseVal), .busVal(busVal), .memRdata(memRdata),
    .memReady(memReady), .busy(busy), .memReq(memReq), .marLoad(marLoad),
    .marSel(marSel), .marAddr(marAddr), .pcLoad(pcLoad), .pcSel(pcSel),
    .pcNext(pcNext), .leaWrite(leaWrite), .leaValue(leaValue)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] sx9(input logic [8:0] v);
    return {{7{v[8]}}, v};
  endfunction
  function automatic logic [15:0] sx6(input logic [5:0] v);
    return {{10{v[5]}}, v};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doDirect(input logic [3:0] k, input logic [8:0] f, input logic [15:0] pc,
                          input logic [15:0] base, input logic [15:0] bus);
    logic [15:0] pcRel, bOff;
    string tag;
    @(negedge clk);
    opValid = 1'b1; opKind = k; irField = f; pcVal = pc; baseVal = base; busVal = bus;
    memReady = 1'b0;
    #2;
    pcRel = pc + sx9(f);
    bOff  = base + sx6(f[5:0]);
    chk("R10 idle", {15'd0, busy}, 16'd0);
    chk("R3 no request", {15'd0, memReq}, 16'd0);
    case (k)
      4'd0: begin
        chk("R2 pcLoad", {15'd0, pcLoad}, 16'd1);
        chk("R2 pcSel", {14'd0, pcSel}, 16'd0);
        chk("R2 pcNext", pcNext, pc + 16'd1);
        chk("R2 marLoad", {15'd0, marLoad}, 16'd0);
      end
      4'd1, 4'd2: begin
        tag = "R6";
        chk({tag, " pcLoad"}, {15'd0, pcLoad}, 16'd1);
        chk({tag, " pcSel"}, {14'd0, pcSel}, 16'd1);
        chk({tag, " pcNext"}, pcNext, (k == 4'd1) ? pcRel : base);
      end
      4'd3: begin
        chk("R7 marLoad", {15'd0, marLoad}, 16'd1);
        chk("R7 marSel", {14'd0, marSel}, 16'd1);
        chk("R7 marAddr", marAddr, {8'd0, f[7:0]});
        chk("R7 pcSel", {14'd0, pcSel}, 16'd2);
        chk("R7 pcNext", pcNext, bus);
      end
      4'd4, 4'd5: begin
        chk("R3 marLoad", {15'd0, marLoad}, 16'd1);
        chk("R3 marSel", {14'd0, marSel}, 16'd0);
        chk("R3 marAddr", marAddr, pcRel);
        chk("R3 pcLoad", {15'd0, pcLoad}, 16'd0);
      end
      4'd6, 4'd7: begin
        chk("R4 marLoad", {15'd0, marLoad}, 16'd1);
        chk("R4 marSel", {14'd0, marSel}, 16'd0);
        chk("R4 marAddr", marAddr, bOff);
      end
      4'd10: begin
        chk("R5 leaWrite", {15'd0, leaWrite}, 16'd1);
        chk("R5 leaValue", leaValue, pcRel);
        chk("R5 marLoad", {15'd0, marLoad}, 16'd0);
        chk("R5 pcLoad", {15'd0, pcLoad}, 16'd0);
      end
      default: begin
        chk("R11 strobes", {12'd0, marLoad, pcLoad, leaWrite, memReq}, 16'd0);
      end
    endcase
    if (k != 4'd10) chk("R5 leaWrite other", {15'd0, leaWrite}, 16'd0);
  endtask

  task automatic doIndirect(input logic [3:0] k, input logic [8:0] f, input logic [15:0] pc,
                            input logic [15:0] ptr, input int waitN);
    logic [15:0] loc;
    @(negedge clk);
    opValid = 1'b1; opKind = k; irField = f; pcVal = pc; memReady = 1'b0;
    #2;
    loc = pc + sx9(f);
    chk("R8 accept no strobes", {12'd0, busy, marLoad, pcLoad, memReq}, 16'd0);
    for (int c = 0; c <= waitN; c++) begin
      @(negedge clk);
      opValid = 1'b1; opKind = (c % 2 == 0) ? 4'd0 : 4'd10;
      irField = 9'($urandom); pcVal = 16'($urandom);
      memReady = (c == waitN);
      memRdata = (c == waitN) ? ptr : 16'($urandom);
      #2;
      chk("R8 busy", {15'd0, busy}, 16'd1);
      chk("R8 memReq", {15'd0, memReq}, 16'd1);
      chk("R8 marSel", {14'd0, marSel}, 16'd2);
      chk("R8 marAddr", marAddr, loc);
      chk("R8 marLoad", {15'd0, marLoad}, (c == 0) ? 16'd1 : 16'd0);
      chk("R10 blocked", {14'd0, pcLoad, leaWrite}, 16'd0);
    end
    @(negedge clk);
    memReady = 1'b0; memRdata = 16'($urandom); opKind = 4'd0; pcVal = 16'($urandom);
    #2;
    chk("R9 marLoad", {15'd0, marLoad}, 16'd1);
    chk("R9 marSel", {14'd0, marSel}, 16'd3);
    chk("R9 marAddr", marAddr, ptr);
    chk("R9 memReq", {15'd0, memReq}, 16'd0);
    chk("R10 blocked final", {15'd0, pcLoad}, 16'd0);
    @(negedge clk);
    opValid = 1'b0;
    #2;
    chk("R9 idle after", {15'd0, busy}, 16'd0);
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd2024);
    #1;
    chk("R1 reset strobes", {11'd0, busy, memReq, marLoad, pcLoad, leaWrite}, 16'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R1 after reset", {11'd0, busy, memReq, marLoad, pcLoad, leaWrite}, 16'd0);

    doDirect(4'd0, 9'h000, 16'hFFFF, 16'h0, 16'h0);
    doDirect(4'd4, 9'h001, 16'hFFFF, 16'h0, 16'h0);
    doDirect(4'd5, 9'h100, 16'h0000, 16'h0, 16'h0);
    doDirect(4'd4, 9'h0FF, 16'h3000, 16'h0, 16'h0);
    doDirect(4'd6, 9'h020, 16'h1234, 16'h0010, 16'h0);
    doDirect(4'd7, 9'h01F, 16'h1234, 16'hFFF0, 16'h0);
    doDirect(4'd6, 9'h1DF, 16'h0000, 16'h8000, 16'h0);
    doDirect(4'd10, 9'h0FF, 16'h3000, 16'h0, 16'h0);
    doDirect(4'd1, 9'h1FF, 16'h3000, 16'h0, 16'h0);
    doDirect(4'd2, 9'h155, 16'h3000, 16'hBEEF, 16'h0);
    doDirect(4'd3, 9'h1FF, 16'h3000, 16'h0, 16'h4321);
    doDirect(4'd15, 9'h1FF, 16'h3000, 16'h1111, 16'h2222);
    doDirect(4'd11, 9'h0AA, 16'h3000, 16'h1111, 16'h2222);
    doIndirect(4'd8, 9'h100, 16'h0010, 16'hCAFE, 0);
    doIndirect(4'd9, 9'h0FF, 16'hFF80, 16'h0042, 3);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] k;
      k = 4'($urandom_range(0, 15));
      if (k == 4'd8 || k == 4'd9)
        doIndirect(k, 9'($urandom), 16'($urandom), 16'($urandom), $urandom_range(0, 4));
      else
        doDirect(k, 9'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end

    @(negedge clk);
    opValid = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule